// File: doc/BRIEF.md
# Periodic battery test sequencer

This block decides when a backup battery gets a load test, steps the test through two timed phases, and keeps a low-battery alarm that stays set until it is cleared on purpose. Three events can start a test: the monitor enable bit going from 0 to 1, a top-of-hour pulse from the real-time clock, and a power-up event. A test runs only while the enable bit is set, the supply is good and the oscillator is running. The block turns on an external test load and reads an external comparator during the second phase. It never drives the analog parts directly.

The enable bit is part of a small control/setup register that this block holds, because a battery-insertion event has to clear it. Insertion also clears the alarm, stops any test that is running, and sends a one-cycle reset request to the real-time clock. All interfaces are plain control and status pins. Nothing here carries a data stream, so there is no valid/ready handshake.

Top module: `batt_test_seq`

## Requirements
- R1: After reset, `load_on` is 0, `alarm_flag` is 0, `alarm_n` is 1, `rtc_rst` is 0 and `cfg_q` is all zeros.
- R2: A write to `cfg_q` that sets the enable bit (bit `EN_BIT`, default 0) from 0 to 1 starts a test. `load_on` goes high in the second cycle after the write cycle: one cycle to update the register and one cycle to start.
- R3: While the enable bit is set, a cycle with `hour_pulse` high starts a test, and `load_on` is high from the next cycle. While the enable bit is clear, `hour_pulse` has no effect.
- R4: While the enable bit is set, a cycle with `pwr_up` high starts a test in the same way as R3.
- R5: No trigger starts a test while `vcc_good` is 0 or `osc_run` is 0.
- R6: Once started, `load_on` stays high until `STAB_TICKS` ticks have ended the stabilization phase and `TEST_TICKS` further ticks have ended the test phase. It goes low in the cycle after the last tick. With the defaults this is one tick for each phase.
- R7: `batt_low` sets the alarm flag only during the test phase, including the cycle that holds the phase-ending tick. During the stabilization phase it is ignored.
- R8: `alarm_n` is the inverse of `alarm_flag` in every cycle.
- R9: `stat_wr` clears the alarm flag. A later test that passes leaves the flag set. If a set and `stat_wr` fall in the same cycle, the flag ends up set.
- R10: `batt_insert` clears the alarm flag and `cfg_q` and stops a running test, all on the next edge. It takes priority over every other input. `rtc_rst` is high for exactly the one cycle that follows it.
- R11: If the enable bit, `vcc_good` or `osc_run` goes low during a test, the test stops and `load_on` is low from the next evaluated edge. The alarm is not changed in the cycle of the abort.
- R12: A trigger that arrives during a test is ignored. The running test keeps its length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse once per second |
| hour_pulse | input | 1 | One-cycle pulse at each full hour |
| pwr_up | input | 1 | One-cycle pulse when the supply passes the power-on threshold |
| vcc_good | input | 1 | Supply is adequate |
| osc_run | input | 1 | Real-time clock oscillator is running |
| batt_low | input | 1 | Comparator output, high when the battery is below its trip point |
| stat_wr | input | 1 | Write strobe to the alarm/status register |
| batt_insert | input | 1 | Battery-insertion event |
| cfg_we | input | 1 | Write strobe for the control/setup register |
| cfg_wdata | input | CFG_W | Write data for the control/setup register |
| cfg_q | output | CFG_W | Current control/setup register value |
| load_on | output | 1 | Test-load enable |
| alarm_flag | output | 1 | Sticky low-battery flag |
| alarm_n | output | 1 | Active-low alarm pin |
| rtc_rst | output | 1 | One-cycle real-time clock reset request |

## Verification
Two actions can land in the same cycle. The first pair is an alarm set, from `batt_low` during the test phase, and an alarm clear, from `stat_wr` or `batt_insert`. The bench drives both in one test-phase cycle and expects the set to win over `stat_wr` and the insertion to win over the set. The second pair is the comparator sample and an abort. The bench sweeps the cycle in which enable, supply or oscillator drops while `batt_low` is held high. From the drop position it works out the expected alarm arithmetically: the alarm should be set only if an earlier test-phase cycle was sampled.

// File: rtl/batt_test_pkg.sv
package batt_test_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_STAB = 2'd1,
    PH_TEST = 2'd2
  } phase_t;
endpackage

// File: rtl/bt_trigger.sv
module bt_trigger (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic en,
  input  logic ok,
  input  logic busy,
  input  logic hour_pulse,
  input  logic pwr_up,
  output logic start
);
  logic en_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_prev <= 1'b0;
    else        en_prev <= en;
  end

  always_comb begin
    start = ok && !busy && !kill &&
            ((en && !en_prev) || hour_pulse || pwr_up);
  end

  // R12: a trigger during a test is ignored
  assert_no_start_busy_R12: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !start);
endmodule

// File: rtl/bt_phase.sv
module bt_phase
  import batt_test_pkg::*;
#(
  parameter int STAB_TICKS = 1,
  parameter int TEST_TICKS = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic start,
  input  logic ok,
  input  logic tick,
  output logic busy,
  output logic sample
);
  localparam int MAXT = (STAB_TICKS > TEST_TICKS) ? STAB_TICKS : TEST_TICKS;
  localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;
  localparam logic [CW-1:0] STAB_LAST = CW'(STAB_TICKS - 1);
  localparam logic [CW-1:0] TEST_LAST = CW'(TEST_TICKS - 1);

  phase_t        st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= PH_IDLE;
      cnt <= '0;
    end else if (kill) begin
      st  <= PH_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        PH_IDLE: if (start) begin
          st  <= PH_STAB;
          cnt <= '0;
        end
        PH_STAB: if (!ok) begin
          st <= PH_IDLE;
        end else if (tick) begin
          if (cnt == STAB_LAST) begin
            st  <= PH_TEST;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        PH_TEST: if (!ok) begin
          st <= PH_IDLE;
        end else if (tick) begin
          if (cnt == TEST_LAST) begin
            st  <= PH_IDLE;
            cnt <= '0;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= PH_IDLE;
      endcase
    end
  end

  assign busy   = (st != PH_IDLE);
  assign sample = (st == PH_TEST) && ok && !kill;

  // R11: losing a run condition ends the test on the next edge
  assert_abort_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ok) |=> !busy);
  // R12: the test phase never falls back into stabilization
  assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_TEST) |=> (st != PH_STAB));
endmodule

// File: rtl/bt_alarm.sv
module bt_alarm (
  input  logic clk,
  input  logic rst_n,
  input  logic kill,
  input  logic set_req,
  input  logic wr_clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag <= 1'b0;
    else if (kill)    flag <= 1'b0;
    else if (set_req) flag <= 1'b1;
    else if (wr_clr)  flag <= 1'b0;
  end

  // R9: the flag holds until an explicit clear
  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !kill && !wr_clr) |=> flag);
  // R7: a failed sample always leaves the flag set
  assert_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req && !kill) |=> flag);
endmodule

// File: rtl/batt_test_seq.sv
module batt_test_seq #(
  parameter int CFG_W      = 8,
  parameter int EN_BIT     = 0,
  parameter int STAB_TICKS = 1,
  parameter int TEST_TICKS = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_1hz,
  input  logic             hour_pulse,
  input  logic             pwr_up,
  input  logic             vcc_good,
  input  logic             osc_run,
  input  logic             batt_low,
  input  logic             stat_wr,
  input  logic             batt_insert,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_q,
  output logic             load_on,
  output logic             alarm_flag,
  output logic             alarm_n,
  output logic             rtc_rst
);
  logic en, ok, start, busy, sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= '0;
      rtc_rst <= 1'b0;
    end else begin
      rtc_rst <= batt_insert;
      if (batt_insert) cfg_q <= '0;
      else if (cfg_we) cfg_q <= cfg_wdata;
    end
  end

  assign en = cfg_q[EN_BIT];
  assign ok = en && vcc_good && osc_run;

  bt_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .kill(batt_insert), .en(en), .ok(ok),
    .busy(busy), .hour_pulse(hour_pulse), .pwr_up(pwr_up), .start(start)
  );

  bt_phase #(.STAB_TICKS(STAB_TICKS), .TEST_TICKS(TEST_TICKS)) u_phase (
    .clk(clk), .rst_n(rst_n), .kill(batt_insert), .start(start), .ok(ok),
    .tick(tick_1hz), .busy(busy), .sample(sample)
  );

  bt_alarm u_alarm (
    .clk(clk), .rst_n(rst_n), .kill(batt_insert),
    .set_req(sample && batt_low), .wr_clr(stat_wr), .flag(alarm_flag)
  );

  assign load_on = busy;
  assign alarm_n = ~alarm_flag;

  // R10: insertion clears state and requests a clock reset
  assert_insert_R10: assert property (@(posedge clk) disable iff (!rst_n)
    batt_insert |=> (cfg_q == '0 && !alarm_flag && rtc_rst && !load_on));
  // R5: a test only begins with supply and oscillator present
  assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_on) |-> $past(vcc_good && osc_run));
endmodule

// File: tb/batt_test_seq_test.sv
`timescale 1ns/1ps
module batt_test_seq_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 0, hour = 0, por = 0, vcc = 0, osc = 0, blow = 0, swr = 0, ins = 0, cfg_we = 0;
  logic [7:0] cfg_wd = '0;
  logic [7:0] cfg_q;
  logic load_on, alarm, alarm_n, rtc_rst;
  int nchk = 0, nerr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  batt_test_seq uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick), .hour_pulse(hour), .pwr_up(por),
    .vcc_good(vcc), .osc_run(osc), .batt_low(blow), .stat_wr(swr), .batt_insert(ins),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wd), .cfg_q(cfg_q), .load_on(load_on),
    .alarm_flag(alarm), .alarm_n(alarm_n), .rtc_rst(rtc_rst)
  );

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_alarm(input string tag, input int exp);
    chk(tag, alarm, exp);
    chk("R8 alarm_n", alarm_n, !exp);
  endtask

  task automatic clear_alarm();
    swr = 1; cyc(); swr = 0;
  endtask

  task automatic hour_start();
    hour = 1; cyc(); hour = 0;
  endtask

  // cycles 0..3 stabilization (tick at 3), 4..7 test phase (tick at 7)
  task automatic run_test(input int lowpos);
    for (int c = 0; c < 8; c++) begin
      tick = (c == 3 || c == 7);
      blow = (c == lowpos);
      cyc();
    end
    tick = 0; blow = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  end

  initial begin
    cyc(); cyc();
    rst_n = 1; cyc();
    chk("R1 load_on", load_on, 0);
    chk_alarm("R1 alarm", 0);
    chk("R1 cfg_q", cfg_q, 0);
    chk("R1 rtc_rst", rtc_rst, 0);

    // R3 disabled: hour pulse ignored
    vcc = 1; osc = 1;
    hour_start();
    chk("R3 disabled hour", load_on, 0);

    // R2 enable rise
    cfg_we = 1; cfg_wd = 8'h01; cyc(); cfg_we = 0;
    chk("R2 one cycle after write", load_on, 0);
    cyc();
    chk("R2 load on", load_on, 1);
    tick = 1; cyc(); tick = 0;
    chk("R6 after stab tick", load_on, 1);
    cyc(); cyc();
    chk("R6 test phase holds", load_on, 1);
    tick = 1; cyc(); tick = 0;
    chk("R6 end after test tick", load_on, 0);

    // R3 / R4 starts
    hour_start();
    chk("R3 hour start", load_on, 1);
    run_test(99);
    chk("R6 length", load_on, 0);
    por = 1; cyc(); por = 0;
    chk("R4 power-up start", load_on, 1);
    run_test(99);

    // R5 gating
    vcc = 0; hour_start(); chk("R5 vcc low", load_on, 0);
    vcc = 1; osc = 0; hour_start(); chk("R5 osc low", load_on, 0);
    por = 1; cyc(); por = 0; chk("R5 osc low por", load_on, 0);
    osc = 1;

    // R7 sweep of comparator position
    for (int p = 0; p < 9; p++) begin
      clear_alarm();
      hour_start();
      run_test(p);
      chk_alarm($sformatf("R7 low at cycle %0d", p), (p >= 4 && p <= 7) ? 1 : 0);
      chk("R6 done", load_on, 0);
    end

    // R9 sticky across a passing test
    clear_alarm();
    hour_start(); run_test(5);
    chk_alarm("R9 set", 1);
    hour_start(); run_test(99);
    chk_alarm("R9 sticky after pass", 1);
    clear_alarm();
    chk_alarm("R9 write clears", 0);
    // R9 set and clear in the same cycle
    hour_start();
    for (int c = 0; c < 8; c++) begin
      tick = (c == 3 || c == 7);
      blow = (c == 5); swr = (c == 5);
      cyc();
    end
    tick = 0; blow = 0; swr = 0;
    chk_alarm("R9 set beats write", 1);
    clear_alarm();

    // R12 triggers during a test
    hour_start();
    for (int c = 0; c < 8; c++) begin
      tick = (c == 3 || c == 7);
      hour = (c == 1 || c == 5); por = (c == 2 || c == 6);
      cyc();
      if (c == 6) chk("R12 still running", load_on, 1);
    end
    tick = 0; hour = 0; por = 0;
    chk("R12 length unchanged", load_on, 0);

    // R11 abort sweep: s 0 enable, 1 vcc, 2 osc
    for (int s = 0; s < 3; s++) begin
      for (int p = 0; p < 7; p++) begin
        int eff;
        eff = p + ((s == 0) ? 1 : 0);
        clear_alarm();
        hour_start();
        blow = 1;
        for (int c = 0; c <= eff; c++) begin
          tick = (c == 3 || c == 7);
          if (c == p) begin
            if (s == 0) begin cfg_we = 1; cfg_wd = 8'h00; end
            if (s == 1) vcc = 0;
            if (s == 2) osc = 0;
          end
          cyc();
          cfg_we = 0;
        end
        tick = 0; blow = 0;
        chk($sformatf("R11 abort load s%0d p%0d", s, p), load_on, 0);
        chk_alarm($sformatf("R11 abort alarm s%0d p%0d", s, p), (eff >= 5) ? 1 : 0);
        vcc = 0; osc = 1;
        cfg_we = 1; cfg_wd = 8'h01; cyc(); cfg_we = 0;
        cyc(); vcc = 1; cyc();
        chk("R11 quiet restore", load_on, 0);
      end
    end

    // R10 insertion mid-test with a simultaneous failed sample
    clear_alarm();
    hour_start(); run_test(4);
    chk_alarm("R10 pre alarm", 1);
    hour_start();
    for (int c = 0; c < 5; c++) begin tick = (c == 3); cyc(); end
    tick = 0;
    blow = 1; ins = 1; cyc(); ins = 0; blow = 0;
    chk("R10 load off", load_on, 0);
    chk_alarm("R10 alarm cleared", 0);
    chk("R10 cfg cleared", cfg_q, 0);
    chk("R10 rtc_rst", rtc_rst, 1);
    cyc();
    chk("R10 rtc_rst one cycle", rtc_rst, 0);
    hour_start();
    chk("R10 disabled afterwards", load_on, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
    $finish;
  end
endmodule